// File: doc/BRIEF.md
# Serial EEPROM slave controller (512 x 8)

This block is the device side of a four-wire serial memory. A host pulls chip select low, clocks an instruction byte in on the serial input, and then sends the address and data bytes that the instruction calls for. Read data and the status byte come back on the serial output, most significant bit first. Input bits are sampled on the rising serial clock edge and output bits change on the falling edge. The array holds 512 bytes in a synthesizable register array. A write command programs one to four bytes of one aligned four-byte group in a single self-timed cycle. A fixed-length internal timer stands in for that programming time. During it the status byte reports busy and only status reads are accepted.

Writes are guarded on three levels. A write-enable latch is set and cleared by two dedicated instructions and clears itself at the end of every programming cycle. An active-low write-protect pin inhibits all programming. A two-bit field in the status register protects the top quarter, the top half or the whole array. A HOLD input stalls a transfer without ending it: while it is low the block ignores the serial clock and data and releases the output.

All pins are sampled in the `clk` domain, so the serial clock half period must be at least three `clk` cycles. The byte stream carries no valid/ready handshake, because the host paces every bit with the serial clock. The only back-pressure is HOLD, which the host uses to pause its own stream. The output pair `so`/`so_en` maps onto a tri-state pad: `so_en` high means the block drives `so`.

Top module: `spi_ee_top`

## Requirements
- R1: After reset `so_en` is low, the status byte reads 0x00 and every array byte reads 0x00.
- R2: The status byte has bit 0 = busy, bit 1 = write-enable latch, bits 3:2 = protect level and bits 7:4 = 0. Opcode 0x06 sets the latch and opcode 0x04 clears it. Opcode 0x05 returns the status byte.
- R3: Opcode 0x03 reads the array. Address bit 8 travels in opcode bit 3 (so 0x0B reads the upper half), followed by the low address byte. Each data byte is shifted out MSB first, changing after a falling serial clock edge and stable before the next rising edge. The address increments after each byte and wraps from 0x1FF to 0x000.
- R4: Opcode 0x02 writes the array, with address bit 8 carried in opcode bit 3. It is followed by the low address byte and one or more data bytes. Successive bytes advance only the low two address bits, so they wrap inside the aligned group of four. A later byte overwrites an earlier one at the same place. The other bytes of the group keep their contents.
- R5: A write or status write sent while the latch is clear changes nothing and starts no programming cycle.
- R6: Busy is set from the chip-select rise that starts a programming cycle until PROG_CYCLES clocks later. During that time opcode 0x05 still works. Every other instruction is ignored: it drives no output and does not change the latch.
- R7: The latch is clear when a programming cycle completes.
- R8: Opcode 0x01 followed by a data byte loads its bits 3:2 into the protect level when its programming cycle completes. The protect levels are: 00 none, 01 addresses 0x180-0x1FF, 10 addresses 0x100-0x1FF, 11 all addresses. A write whose start address lies in the protected range is ignored, starts no cycle and leaves the latch set.
- R9: While `wp_n` is low, neither array nor status writes start a programming cycle, and the latch is left unchanged.
- R10: A write ends without programming if chip select rises part-way through a byte or before any data byte has completed.
- R11: While `hold_n` is low with chip select low, `so_en` is low and serial clock and data are ignored. After `hold_n` goes high again, the transfer continues at the bit where it stopped.
- R12: `so_en` is high only during the data phase of a read or status read, and is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause of the current transfer |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | High when `so` should be driven onto the bus |

## Verification
The write path is exercised with several patterns. A single byte shows the basic store. A five-byte run starting at group offset two exposes the in-group wrap and the overwrite of the first lane. A write with no data bytes and one with four stray bits separate completed bytes from partial ones. Reads cover a run crossing 0x1FF into 0x000, which shows the full-array address wrap and the use of opcode bit 3. Each protect level is tried with one address just inside its range and one just outside, which pins down the boundaries. Instructions sent during a cycle, a write under a low `wp_n`, and a read paused by HOLD with clock pulses in the gap show that the ignore and pause rules neither lose nor invent bits.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_HIMASK = 8'hF7;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_WDAT,
    ST_RDAT,
    ST_SRDAT,
    ST_WSDAT,
    ST_SKIP
  } ee_state_t;
endpackage

// File: rtl/spi_ee_serial.sv
module spi_ee_serial (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       hold_n,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       sel,
  output logic       cs_rise,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       mid_byte,
  output logic       so,
  output logic       so_en
);
  logic       cs_q, cs_p, sck_q, sck_p, si_q, hold_q;
  logic       active, rise, fall, tx_on;
  logic [2:0] bit_cnt;
  logic [6:0] sh;
  logic [7:0] tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      cs_p   <= 1'b1;
      sck_q  <= 1'b0;
      sck_p  <= 1'b0;
      si_q   <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      cs_p   <= cs_q;
      sck_q  <= sck;
      sck_p  <= sck_q;
      si_q   <= si;
      hold_q <= hold_n;
    end
  end

  assign sel       = ~cs_q;
  assign cs_rise   = cs_q & ~cs_p;
  assign active    = sel & hold_q;
  assign rise      = active & sck_q & ~sck_p;
  assign fall      = active & ~sck_q & sck_p;
  assign byte_done = rise & (bit_cnt == 3'd7);
  assign rx_byte   = {sh, si_q};
  assign mid_byte  = (bit_cnt != 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n || !sel) begin
      bit_cnt <= 3'd0;
      sh      <= 7'd0;
    end else if (rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      sh      <= {sh[5:0], si_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sel) begin
      tx    <= 8'd0;
      tx_on <= 1'b0;
      so    <= 1'b0;
    end else if (tx_load) begin
      tx    <= tx_byte;
      tx_on <= 1'b1;
    end else if (fall) begin
      so <= tx[7];
      tx <= {tx[6:0], 1'b0};
    end
  end

  assign so_en = tx_on & active;
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [7:0]                    rd_data,
  input  logic                          wr_en,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_grp,
  input  logic [PAGE_BYTES-1:0]         wr_mask,
  input  logic [8*PAGE_BYTES-1:0]       wr_data
);
  localparam int LANE_W = $clog2(PAGE_BYTES);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (wr_en) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (wr_mask[j]) cells[{wr_grp, LANE_W'(j)}] <= wr_data[8*j +: 8];
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES  = 4,
  parameter int PROG_CYCLES = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    cs_rise,
  input  logic                    byte_done,
  input  logic [7:0]              rx_byte,
  input  logic                    mid_byte,
  input  logic                    wp_n,
  input  logic [7:0]              rd_data,
  output logic                    tx_load,
  output logic [7:0]              tx_byte,
  output logic [ADDR_W-1:0]       rd_addr,
  output logic                    wr_en,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_grp,
  output logic [PAGE_BYTES-1:0]   wr_mask,
  output logic [8*PAGE_BYTES-1:0] wr_data,
  output logic                    busy,
  output logic                    wel
);
  localparam int LANE_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(PROG_CYCLES) + 1;
  localparam logic [CNT_W-1:0] T_LAST = CNT_W'(PROG_CYCLES - 1);

  ee_state_t         state;
  logic              is_read, a8, got, wp_q, prog_sr;
  logic [1:0]        bp, sr_new;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  timer;
  logic [7:0]        pbuf [PAGE_BYTES];
  logic [7:0]        status;

  function automatic logic in_prot(input logic [ADDR_W-1:0] a, input logic [1:0] lvl);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return &a[ADDR_W-1 -: 2];
      2'b10:   return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  assign status  = {4'b0000, bp, wel, busy};
  assign rd_addr = (state == ST_ADDR) ? {a8, rx_byte} : addr;
  assign wr_en   = busy & ~prog_sr & (timer == T_LAST);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_pack
    assign wr_data[8*g +: 8] = pbuf[g];
  end

  always_comb begin
    tx_load = 1'b0;
    tx_byte = 8'h00;
    if (byte_done) begin
      case (state)
        ST_CMD:   if (rx_byte == OP_RDSR) begin tx_load = 1'b1; tx_byte = status; end
        ST_ADDR:  if (is_read) begin tx_load = 1'b1; tx_byte = rd_data; end
        ST_RDAT:  begin tx_load = 1'b1; tx_byte = rd_data; end
        ST_SRDAT: begin tx_load = 1'b1; tx_byte = status; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_CMD;
      is_read <= 1'b0;
      a8      <= 1'b0;
      got     <= 1'b0;
      wp_q    <= 1'b1;
      prog_sr <= 1'b0;
      bp      <= 2'b00;
      sr_new  <= 2'b00;
      addr    <= '0;
      wr_grp  <= '0;
      wr_mask <= '0;
      timer   <= '0;
      busy    <= 1'b0;
      wel     <= 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
    end else begin
      wp_q <= wp_n;
      if (!sel) state <= ST_CMD;

      // start of a programming cycle on a clean chip-select rise
      if (cs_rise && !busy && wel && wp_q && !mid_byte && got) begin
        if (state == ST_WDAT && !in_prot({wr_grp, {LANE_W{1'b0}}}, bp)) begin
          busy <= 1'b1; prog_sr <= 1'b0; timer <= '0;
        end else if (state == ST_WSDAT) begin
          busy <= 1'b1; prog_sr <= 1'b1; timer <= '0;
        end
      end

      if (busy) begin
        if (timer == T_LAST) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          if (prog_sr) bp <= sr_new;
        end else begin
          timer <= timer + 1'b1;
        end
      end

      if (sel && byte_done) begin
        case (state)
          ST_CMD: begin
            if (busy && rx_byte != OP_RDSR) state <= ST_SKIP;
            else begin
              case (rx_byte)
                OP_WREN: begin wel <= 1'b1; state <= ST_SKIP; end
                OP_WRDI: begin wel <= 1'b0; state <= ST_SKIP; end
                OP_RDSR: state <= ST_SRDAT;
                OP_WRSR: begin got <= 1'b0; state <= ST_WSDAT; end
                default: begin
                  if ((rx_byte & OP_HIMASK) == OP_READ) begin
                    is_read <= 1'b1; a8 <= rx_byte[3]; state <= ST_ADDR;
                  end else if ((rx_byte & OP_HIMASK) == OP_WRITE) begin
                    is_read <= 1'b0; a8 <= rx_byte[3]; state <= ST_ADDR;
                  end else state <= ST_SKIP;
                end
              endcase
            end
          end
          ST_ADDR: begin
            if (is_read) begin
              addr  <= rd_addr + 1'b1;
              state <= ST_RDAT;
            end else begin
              addr    <= rd_addr;
              wr_grp  <= rd_addr[ADDR_W-1:LANE_W];
              wr_mask <= '0;
              got     <= 1'b0;
              state   <= ST_WDAT;
            end
          end
          ST_RDAT: addr <= addr + 1'b1;
          ST_WDAT: begin
            pbuf[addr[LANE_W-1:0]]    <= rx_byte;
            wr_mask[addr[LANE_W-1:0]] <= 1'b1;
            addr[LANE_W-1:0]          <= addr[LANE_W-1:0] + 1'b1;
            got                       <= 1'b1;
          end
          ST_WSDAT: begin
            sr_new <= rx_byte[3:2];
            got    <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ee_top.sv
module spi_ee_top
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES  = 4,
  parameter int PROG_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_en
);
  localparam int LANE_W = $clog2(PAGE_BYTES);

  logic                     sel, cs_rise, byte_done, mid_byte, tx_load;
  logic [7:0]               rx_byte, tx_byte, rd_data;
  logic [ADDR_W-1:0]        rd_addr;
  logic                     wr_en, busy, wel;
  logic [ADDR_W-LANE_W-1:0] wr_grp;
  logic [PAGE_BYTES-1:0]    wr_mask;
  logic [8*PAGE_BYTES-1:0]  wr_data;

  spi_ee_serial u_serial (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .tx_load(tx_load), .tx_byte(tx_byte), .sel(sel), .cs_rise(cs_rise),
    .byte_done(byte_done), .rx_byte(rx_byte), .mid_byte(mid_byte),
    .so(so), .so_en(so_en)
  );

  spi_ee_ctrl #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cs_rise(cs_rise), .byte_done(byte_done),
    .rx_byte(rx_byte), .mid_byte(mid_byte), .wp_n(wp_n), .rd_data(rd_data),
    .tx_load(tx_load), .tx_byte(tx_byte), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_grp(wr_grp), .wr_mask(wr_mask), .wr_data(wr_data), .busy(busy), .wel(wel)
  );

  spi_ee_array #(.PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_mask(wr_mask), .wr_data(wr_data)
  );
endmodule

// File: rtl/spi_ee_chk.sv
module spi_ee_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic hold_n,
  input logic wp_n,
  input logic so_en,
  input logic busy,
  input logic wel,
  input logic wr_en
);
  // R12
  so_off_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !so_en);

  // R11
  so_off_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hold_n) |-> !so_en);

  // R5
  prog_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R9
  prog_needs_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wp_n, 2));

  // R7
  latch_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R4
  commit_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $fell(busy));
endmodule

bind spi_ee_top spi_ee_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .wp_n(wp_n),
  .so_en(so_en), .busy(busy), .wel(wel), .wr_en(wr_en)
);

// File: tb/sim_spi_ee_top.sv
module sim_spi_ee_top;
  localparam int HP   = 4;
  localparam int PROG = 1000;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_en;

  always #4 clk = ~clk;

  spi_ee_top #(.PAGE_BYTES(4), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [512];
  logic [7:0] wbuf [8];
  logic [1:0] mbp = 2'b00;
  logic       mwel = 1'b0;
  logic       cs_d = 1'b1, hold_d = 1'b1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // R12 / R11: every clock, output must be released when deselected or held
  always @(posedge clk) begin cs_d <= cs_n; hold_d <= hold_n; end
  always @(negedge clk) if (rst_n && (cs_d || !hold_d)) chk("R12 so_en idle", so_en, 0);

  function automatic bit mprot(input int a);
    if (mbp == 2'b11) return 1;
    if (mbp == 2'b10) return a >= 256;
    if (mbp == 2'b01) return a >= 384;
    return 0;
  endfunction

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic sbit(input logic b, output logic o, output logic oe);
    si = b; tick(HP); o = so; oe = so_en; sck = 1'b1; tick(HP); sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q, output logic oe_all);
    logic o, oe;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin sbit(d[i], o, oe); q[i] = o; oe_all &= oe; end
  endtask

  task automatic cs_lo; cs_n = 1'b0; tick(HP); endtask
  task automatic cs_hi; tick(HP); cs_n = 1'b1; tick(2*HP); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] q; logic e;
    cs_lo; xfer(op, q, e); cs_hi;
  endtask

  task automatic wren; cmd1(8'h06); mwel = 1'b1; endtask
  task automatic wrdi; cmd1(8'h04); mwel = 1'b0; endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] q; logic e;
    cs_lo; xfer(8'h05, q, e); xfer(8'h00, s, e); cs_hi;
  endtask

  task automatic wait_ready;
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin rdsr(s); if (!s[0]) break; end
    chk("R7 status after cycle", s, {4'b0, mbp, 2'b00});
  endtask

  task automatic do_read(input logic [8:0] a, input int n, input string tag);
    logic [7:0] q; logic e;
    cs_lo; xfer({4'b0000, a[8], 3'b011}, q, e); xfer(a[7:0], q, e);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, q, e);
      chk({tag, " data"}, q, mdl[(int'(a) + i) % 512]);
      chk({tag, " drive"}, e, 1);
    end
    cs_hi;
  endtask

  task automatic do_write(input logic [8:0] a, input int n, input int xbits,
                          input bit probe, input string tag);
    logic [7:0] q; logic e, o, oe; bit go; int ia;
    ia = int'(a);
    go = mwel && wp_n && xbits == 0 && n > 0 && !mprot(ia);
    cs_lo; xfer({4'b0000, a[8], 3'b010}, q, e); xfer(a[7:0], q, e);
    for (int i = 0; i < n; i++) xfer(wbuf[i], q, e);
    for (int i = 0; i < xbits; i++) sbit(1'b1, o, oe);
    cs_hi;
    rdsr(q);
    chk({tag, " status"}, q, go ? {4'b0, mbp, 2'b11} : {4'b0, mbp, mwel, 1'b0});
    if (go) begin
      if (probe) begin
        // R6: read and latch set are ignored while busy
        cs_lo; xfer(8'h03, q, e); xfer(8'h00, q, e); xfer(8'h00, q, e);
        chk("R6 no drive when busy", e, 0); cs_hi;
        cmd1(8'h06);
      end
      wait_ready;
      for (int i = 0; i < n; i++) mdl[(ia & ~3) | ((ia + i) & 3)] = wbuf[i];
      mwel = 1'b0;
    end
  endtask

  task automatic do_wrsr(input logic [7:0] v, input string tag);
    logic [7:0] q; logic e; bit go;
    go = mwel && wp_n;
    cs_lo; xfer(8'h01, q, e); xfer(v, q, e); cs_hi;
    rdsr(q);
    chk({tag, " status"}, q, go ? {4'b0, mbp, 2'b11} : {4'b0, mbp, mwel, 1'b0});
    if (go) begin mbp = v[3:2]; mwel = 1'b0; wait_ready; end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    summary;
    $finish;
  end

  initial begin
    logic [7:0] s, q; logic o, oe, e;
    for (int i = 0; i < 512; i++) mdl[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(2);

    // R1
    chk("R1 so_en", so_en, 0);
    rdsr(s); chk("R1 status", s, 8'h00);
    do_read(9'h000, 2, "R1");

    // R2
    wren; rdsr(s); chk("R2 latch set", s, 8'h02);
    wrdi; rdsr(s); chk("R2 latch clear", s, 8'h00);

    // R5
    wbuf[0] = 8'hA5; do_write(9'h010, 1, 0, 0, "R5");
    do_read(9'h010, 1, "R5");

    // R4: five bytes from offset 2, wrapping inside the group
    wren;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h55;
    do_write(9'h106, 5, 0, 0, "R4");
    do_read(9'h103, 6, "R4");

    // R6 / R7 then R3 full-array wrap
    wren;
    wbuf[0] = 8'hC0; wbuf[1] = 8'hC1; wbuf[2] = 8'hC2; wbuf[3] = 8'hC3;
    do_write(9'h1FC, 4, 0, 1, "R6");
    wren; wbuf[0] = 8'hD0; wbuf[1] = 8'hD1;
    do_write(9'h000, 2, 0, 0, "R4");
    do_read(9'h1FE, 4, "R3");

    // R8: each protect level at its boundary
    wren; do_wrsr(8'h04, "R8");
    rdsr(s); chk("R8 level 01", s, 8'h04);
    wren; wbuf[0] = 8'hEE; do_write(9'h180, 1, 0, 0, "R8");
    wbuf[0] = 8'h5A; do_write(9'h17C, 1, 0, 0, "R8");
    do_read(9'h17C, 8, "R8");
    wren; do_wrsr(8'h0C, "R8");
    wren; wbuf[0] = 8'hEE; do_write(9'h000, 1, 0, 0, "R8");
    do_wrsr(8'h08, "R8");
    wren; do_write(9'h100, 1, 0, 0, "R8");
    wbuf[0] = 8'h6B; do_write(9'h0FC, 1, 0, 0, "R8");
    do_read(9'h0FC, 8, "R8");
    do_read(9'h000, 1, "R8");
    wren; do_wrsr(8'h00, "R8");

    // R9
    wp_n = 1'b0; tick(4);
    wren; wbuf[0] = 8'h99; do_write(9'h020, 1, 0, 0, "R9");
    do_wrsr(8'h0C, "R9");
    wp_n = 1'b1; tick(4); wrdi;
    do_read(9'h020, 1, "R9");
    rdsr(s); chk("R9 level kept", s, 8'h00);

    // R10
    wren; wbuf[0] = 8'h12; do_write(9'h030, 1, 4, 0, "R10");
    do_write(9'h031, 0, 0, 0, "R10");
    wrdi; do_read(9'h030, 2, "R10");

    // R11: pause a read mid-byte with clock pulses in the gap
    cs_lo; xfer(8'h0B, q, e); xfer(8'h04, q, e);
    q = 8'h00;
    for (int i = 7; i >= 5; i--) begin sbit(1'b0, o, oe); q[i] = o; end
    tick(HP); hold_n = 1'b0; tick(3);
    chk("R11 released in hold", so_en, 0);
    for (int k = 0; k < 2; k++) begin si = 1'b1; sck = 1'b1; tick(2); sck = 1'b0; si = 1'b0; tick(2); end
    chk("R11 still released", so_en, 0);
    hold_n = 1'b1; tick(3);
    for (int i = 4; i >= 0; i--) begin sbit(1'b0, o, oe); q[i] = o; end
    chk("R11 resumed byte", q, mdl[9'h104]);
    xfer(8'h00, q, e); chk("R11 next byte", q, mdl[9'h105]);
    cs_hi;

    summary;
    $finish;
  end
endmodule